// File: doc/BRIEF.md
# Banked Instruction Memory Preload Controller

This block lets software fill an instruction memory before the processor starts fetching from it. The memory is built from two banks, even and odd, that share one word address. Software uses a small register bus with 10-bit register addresses and 32-bit data. It first writes a start pointer into a pointer register. It then writes instruction words, one at a time, into a fill register. Each fill write becomes exactly one 32-bit write into one bank, and the pointer then advances by one.

The pointer is 22 bits wide. Its upper 21 bits form the shared bank address. Its lowest bit selects the bank. A run of fills therefore alternates between the even and odd banks, and the shared address steps once every two words.

The bus is plain control, not a stream. A request is a single-cycle `bus_req` pulse. The controller never applies back-pressure: every request is accepted, and `bus_ack` (with `bus_rdata` for reads) follows exactly one clock later. Requests may be issued on consecutive cycles. Bus data uses big-endian bit names, where name bit n is vector bit 31-n. Name bits 8..29 are therefore `bus_wdata[23:2]`.

Top module: `imem_preload_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the pointer to zero and drives `bus_ack`, `bus_rdata`, both bank write enables and both bank enables low. This holds even when a fill request is present during reset.
- R2: A write to `INIT_REG_ADDR` loads the pointer from name bits 8..29, which are `bus_wdata[23:2]`. All other data bits are ignored, and no bank write happens.
- R3: A write to `FILL_REG_ADDR` produces exactly one bank write-enable pulse. The pulse is one clock long and appears in the cycle right after the request cycle.
- R4: During a fill pulse, `mem_addr` equals pointer bits [21:1], which are name bits 8..28, taken before the increment. Both banks share this address.
- R5: Pointer bit 0 (name bit 29) selects the bank. Value 0 pulses `mem_we_even`, value 1 pulses `mem_we_odd`, and the two are never high together.
- R6: `mem_en_even` and `mem_en_odd` pulse in the same cycle as the write enable of their own bank, and at no other time.
- R7: During a fill pulse, `mem_wdata` equals all 32 bits of the fill write data, with each bit in its own position.
- R8: Every fill write increments the whole 22-bit pointer by one. Consecutive fills therefore alternate banks, and `mem_addr` advances every second fill.
- R9: A fill at pointer 22'h3FFFFF writes the odd bank at address 21'h1FFFFF. The pointer then wraps to zero.
- R10: `bus_ack` is high in the cycle after every request, whatever its address or direction, and is low otherwise.
- R11: A read of `INIT_REG_ADDR` returns the current pointer in `bus_rdata[23:2]` with all other bits zero. A read of any other address returns zero.
- R12: A write to any address other than the two registers raises no bank strobe and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | One-cycle register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Register address |
| bus_wdata | input | 32 | Write data (name bit n = vector bit 31-n) |
| bus_ack | output | 1 | Access acknowledge, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| mem_addr | output | 21 | Shared bank word address |
| mem_wdata | output | 32 | Word written to the selected bank |
| mem_we_even | output | 1 | Even bank write enable |
| mem_we_odd | output | 1 | Odd bank write enable |
| mem_en_even | output | 1 | Even bank enable |
| mem_en_odd | output | 1 | Odd bank enable |

## Verification
The assertions assume that the bus inputs are known whenever `bus_req` is high and that every cycle with `bus_req` high is one separate access. They also assume reset is applied at the start, before any access. The stimulus changes all inputs only on falling clock edges, holds `rst` high from time zero, and uses back-to-back requests only as distinct accesses with fresh data. The assertions compare the memory strobes against a pointer model that is updated from bus traffic alone.

// File: rtl/imem_preload_pkg.sv
package imem_preload_pkg;
  localparam int unsigned BUS_DW  = 32;            // register bus data width
  localparam int unsigned REG_AW  = 10;            // register address width
  localparam int unsigned PTR_W   = 22;            // fill pointer width
  localparam int unsigned MEM_AW  = PTR_W - 1;     // shared bank address width
  localparam int unsigned PTR_LSB = 2;             // vector position of name bit 29
  localparam int unsigned NBANK   = 2;             // even and odd banks

  typedef logic [PTR_W-1:0] ptr_t;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_PTR_WR,
    ACC_FILL_WR,
    ACC_PTR_RD
  } acc_e;
endpackage

// File: rtl/ipl_decode.sv
module ipl_decode
  import imem_preload_pkg::*;
#(
  parameter logic [REG_AW-1:0] PTR_ADDR  = '0,
  parameter logic [REG_AW-1:0] FILL_ADDR = '0
) (
  input  logic              req,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  output acc_e              acc
);
  always_comb begin
    acc = ACC_NONE;
    if (req) begin
      if (addr == PTR_ADDR) begin
        acc = we ? ACC_PTR_WR : ACC_PTR_RD;
      end else if (addr == FILL_ADDR && we) begin
        acc = ACC_FILL_WR;
      end
    end
  end
endmodule

// File: rtl/ipl_pointer.sv
module ipl_pointer
  import imem_preload_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  ptr_t load_val,
  input  logic step,
  output ptr_t ptr
);
  // Increment wraps naturally from all ones to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (step) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ipl_wport.sv
module ipl_wport
  import imem_preload_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fill,
  input  ptr_t              ptr,
  input  logic [BUS_DW-1:0] wdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [BUS_DW-1:0] mem_wdata,
  output logic [NBANK-1:0]  bank_we,
  output logic [NBANK-1:0]  bank_en
);
  localparam int unsigned SEL_W = $clog2(NBANK);

  logic [SEL_W-1:0] sel;
  assign sel = ptr[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (fill) begin
      mem_addr  <= ptr[PTR_W-1:SEL_W];
      mem_wdata <= wdata;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_we[b] <= 1'b0;
        bank_en[b] <= 1'b0;
      end else begin
        bank_we[b] <= fill && (sel == SEL_W'(b));
        bank_en[b] <= fill && (sel == SEL_W'(b));
      end
    end
  end
endmodule

// File: rtl/imem_preload_ctrl.sv
module imem_preload_ctrl
  import imem_preload_pkg::*;
#(
  parameter logic [REG_AW-1:0] INIT_REG_ADDR = 10'h0A0,
  parameter logic [REG_AW-1:0] FILL_REG_ADDR = 10'h0A1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [BUS_DW-1:0] mem_wdata,
  output logic              mem_we_even,
  output logic              mem_we_odd,
  output logic              mem_en_even,
  output logic              mem_en_odd
);
  localparam int unsigned HI_PAD = BUS_DW - PTR_W - PTR_LSB;

  acc_e             acc;
  ptr_t             ptr;
  logic [NBANK-1:0] bank_we;
  logic [NBANK-1:0] bank_en;
  logic [BUS_DW-1:0] ptr_view;

  ipl_decode #(.PTR_ADDR(INIT_REG_ADDR), .FILL_ADDR(FILL_REG_ADDR)) u_dec (
    .req (bus_req),
    .we  (bus_we),
    .addr(bus_addr),
    .acc (acc)
  );

  ipl_pointer u_ptr (
    .clk     (clk),
    .rst     (rst),
    .load    (acc == ACC_PTR_WR),
    .load_val(bus_wdata[PTR_LSB +: PTR_W]),
    .step    (acc == ACC_FILL_WR),
    .ptr     (ptr)
  );

  ipl_wport u_wp (
    .clk      (clk),
    .rst      (rst),
    .fill     (acc == ACC_FILL_WR),
    .ptr      (ptr),
    .wdata    (bus_wdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .bank_we  (bank_we),
    .bank_en  (bank_en)
  );

  assign ptr_view = {{HI_PAD{1'b0}}, ptr, {PTR_LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req;
      bus_rdata <= (acc == ACC_PTR_RD) ? ptr_view : '0;
    end
  end

  assign mem_we_even = bank_we[0];
  assign mem_we_odd  = bank_we[1];
  assign mem_en_even = bank_en[0];
  assign mem_en_odd  = bank_en[1];
endmodule

// File: rtl/ipl_chk.sv
module ipl_chk
  import imem_preload_pkg::*;
#(
  parameter logic [REG_AW-1:0] INIT_ADDR = '0,
  parameter logic [REG_AW-1:0] FILL_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              bus_ack,
  input logic [BUS_DW-1:0] bus_rdata,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [BUS_DW-1:0] mem_wdata,
  input logic              mem_we_even,
  input logic              mem_we_odd,
  input logic              mem_en_even,
  input logic              mem_en_odd
);
  logic fill_req, init_wr, rd_other, we_any, live;
  ptr_t mdl;

  assign fill_req = bus_req && bus_we && (bus_addr == FILL_ADDR);
  assign init_wr  = bus_req && bus_we && (bus_addr == INIT_ADDR);
  assign rd_other = bus_req && !bus_we && (bus_addr != INIT_ADDR);
  assign we_any   = mem_we_even || mem_we_odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdl  <= '0;
      live <= 1'b0;
    end else begin
      live <= 1'b1;
      if (init_wr) mdl <= bus_wdata[PTR_LSB +: PTR_W];
      else if (fill_req) mdl <= mdl + 1'b1;
    end
  end

  // R3
  fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(fill_req) |-> we_any);
  // R12
  no_stray_we_chk: assert property (@(posedge clk) disable iff (rst)
    we_any |-> live && $past(fill_req));
  // R5
  bank_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we_even, mem_we_odd}));
  // R8
  ptr_seq_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(fill_req) |-> {mem_addr, mem_we_odd} == $past(mdl));
  // R6
  en_match_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_en_even == mem_we_even) && (mem_en_odd == mem_we_odd));
  // R7
  fill_data_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(fill_req) |-> mem_wdata == $past(bus_wdata));
  // R10
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> bus_ack == $past(bus_req));
  // R11
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    live && $past(rd_other) |-> bus_rdata == '0);
endmodule

bind imem_preload_ctrl ipl_chk #(
  .INIT_ADDR(INIT_REG_ADDR),
  .FILL_ADDR(FILL_REG_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_ack    (bus_ack),
  .bus_rdata  (bus_rdata),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_we_even(mem_we_even),
  .mem_we_odd (mem_we_odd),
  .mem_en_even(mem_en_even),
  .mem_en_odd (mem_en_odd)
);

// File: tb/tb_imem_preload_ctrl.sv
module tb_imem_preload_ctrl;
  localparam logic [9:0] IA = 10'h0A0;
  localparam logic [9:0] FA = 10'h0A1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [20:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_we_even, mem_we_odd, mem_en_even, mem_en_odd;

  int n_run = 0;
  int n_fail = 0;
  logic [21:0] mdl = '0;

  always #4ns clk = ~clk;

  imem_preload_ctrl #(.INIT_REG_ADDR(IA), .FILL_REG_ADDR(FA)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we_even(mem_we_even), .mem_we_odd(mem_we_odd),
    .mem_en_even(mem_en_even), .mem_en_odd(mem_en_odd)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access; returns at the falling edge where its result is visible.
  task automatic access(input logic we, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic check_quiet(input string tag);
    chk({mem_we_even, mem_we_odd, mem_en_even, mem_en_odd} == 4'b0, tag,
        {28'b0, mem_we_even, mem_we_odd, mem_en_even, mem_en_odd}, 32'h0);
  endtask

  task automatic read_ptr(input string tag);
    access(1'b0, IA, 32'hFFFF_FFFF);
    chk(bus_ack, {tag, " ack"}, {31'b0, bus_ack}, 32'h1);
    chk(bus_rdata == {8'h00, mdl, 2'b00}, tag, bus_rdata, {8'h00, mdl, 2'b00});
  endtask

  task automatic load_ptr(input logic [21:0] v);
    access(1'b1, IA, {8'hA5, v, 2'b11});
    mdl = v;
    check_quiet("R2 no strobe on pointer write");
    read_ptr("R2 pointer load");
  endtask

  // Check the bank write made by a fill that was just issued.
  task automatic check_fill(input logic [31:0] d);
    chk(bus_ack, "R10 fill ack", {31'b0, bus_ack}, 32'h1);
    chk(mem_we_even == !mdl[0] && mem_we_odd == mdl[0], "R5 bank select",
        {30'b0, mem_we_odd, mem_we_even}, {30'b0, mdl[0], !mdl[0]});
    chk(mem_en_even == !mdl[0] && mem_en_odd == mdl[0], "R6 bank enable",
        {30'b0, mem_en_odd, mem_en_even}, {30'b0, mdl[0], !mdl[0]});
    chk(mem_addr == mdl[21:1], "R4 shared address", {11'b0, mem_addr}, {11'b0, mdl[21:1]});
    chk(mem_wdata == d, "R7 fill data", mem_wdata, d);
    mdl = mdl + 1'b1;
  endtask

  task automatic fill(input logic [31:0] d);
    access(1'b1, FA, d);
    check_fill(d);
    @(negedge clk);
    check_quiet("R3 single-cycle pulse");
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!bus_ack && bus_rdata == 0, "R1 bus idle after reset", bus_rdata, 32'h0);
    check_quiet("R1 strobes low after reset");
    chk(mem_addr == 0, "R1 address cleared", {11'b0, mem_addr}, 32'h0);
    read_ptr("R1 pointer zero");
  endtask

  task automatic t_even_run();
    load_ptr(22'h000010);
    for (int i = 0; i < 4; i++) fill(32'hC0DE_0000 + 32'(i) * 32'h0101_0101);
    read_ptr("R8 pointer advanced by four");
  endtask

  task automatic t_odd_start();
    load_ptr(22'h12345);
    fill(32'h8000_0001);
    fill(32'h7FFF_FFFE);
    read_ptr("R8 pointer after odd start");
  endtask

  task automatic t_wrap();
    load_ptr(22'h3FFFFF);
    fill(32'hDEAD_BEEF);
    read_ptr("R9 pointer wrapped");
    chk(mdl == 0, "R9 model wrap", {10'b0, mdl}, 32'h0);
    fill(32'h1234_5678);
  endtask

  task automatic t_ignored();
    load_ptr(22'h00ABC);
    access(1'b1, 10'h0A2, 32'hFFFF_FFFF);
    chk(bus_ack, "R10 ack on unmapped write", {31'b0, bus_ack}, 32'h1);
    check_quiet("R12 no strobe on unmapped write");
    access(1'b0, FA, 32'h0);
    chk(bus_rdata == 0, "R11 fill read zero", bus_rdata, 32'h0);
    access(1'b0, 10'h3FF, 32'h0);
    chk(bus_rdata == 0, "R11 unmapped read zero", bus_rdata, 32'h0);
    read_ptr("R12 pointer unchanged");
    @(negedge clk);
    chk(!bus_ack, "R10 ack low when idle", {31'b0, bus_ack}, 32'h0);
  endtask

  task automatic t_back_to_back();
    load_ptr(22'h00200);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = FA; bus_wdata = 32'hAAAA_0001;
    @(negedge clk);
    check_fill(32'hAAAA_0001);
    bus_wdata = 32'h5555_0002;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    check_fill(32'h5555_0002);
    @(negedge clk);
    check_quiet("R3 pulse ends after back-to-back");
    read_ptr("R8 pointer after back-to-back");
  endtask

  task automatic t_reset_mid();
    load_ptr(22'h0F0F0);
    @(negedge clk);
    rst = 1'b1; bus_req = 1'b1; bus_we = 1'b1; bus_addr = FA; bus_wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    rst = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    check_quiet("R1 fill suppressed by reset");
    chk(!bus_ack, "R1 ack suppressed by reset", {31'b0, bus_ack}, 32'h0);
    mdl = '0;
    read_ptr("R1 pointer cleared by reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_even_run();
    t_odd_start();
    t_wrap();
    t_ignored();
    t_back_to_back();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800us;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule